// File: doc/BRIEF.md
# Main-Controller Fail-Safe Supervisor

This block watches a main controller and decides which side owns the shared network interfaces. A separate monitor reports faults, each marked as transient or permanent. The block also takes a supply-in-window flag, which it samples at a fixed interval, and a flag that says the main controller has recovered. From these inputs it issues reset pulses to the main controller and raises a one-cycle request for a warning message to the connected nodes. It also drives the enables of the main-side and the backup-side communication controllers and transceivers.

A transient fault that clears within a persistence window is ignored. If it lasts longer, the block sends periodic reset pulses until it clears. A permanent fault, or a supply sample out of window, starts a fixed sequence: warning, then reset, then removal of the main side, then enabling of the backup side. Resets keep repeating until the main controller reports recovery. The backup side then finishes its in-progress work before the buses are handed back. Ownership always changes break-before-make, with at least one clock in which neither side is enabled.

Top module: `fs_supervisor`

## Requirements
- R1: After reset, `main_side_en` is 1, and `backup_side_en`, `backup_active`, `main_rst` and `warn_req` are 0.
- R2: A `flt_transient` that is high on PERSIST_CYC or fewer consecutive clock edges, and then low, produces no reset, no warning and no change of enables.
- R3: A `flt_transient` held high on PERSIST_CYC+1 consecutive edges starts a `main_rst` pulse exactly RST_WIDTH cycles wide, rising one cycle after the last of those edges.
- R4: While the fault condition stays, a new reset pulse starts every RETRY_CYC cycles. No new pulse starts once the condition is removed: `flt_transient` low, or `main_recovered` high after a permanent fault.
- R5: A permanent fault seen at edge N gives `warn_req` high for one cycle from edge N+1, `main_rst` rising at N+2, `main_side_en` falling at N+3 and `backup_side_en` rising at N+4.
- R6: `main_side_en` and `backup_side_en` are never high together. Either one rises only if the other was low in the previous cycle. The backup side is never enabled while the main side is in normal supervision.
- R7: `vdd_ok` is sampled once every SAMPLE_CYC cycles. A low sample is handled as a permanent fault, and `warn_req` rises 2 to SAMPLE_CYC+1 cycles after `vdd_ok` falls.
- R8: After `main_recovered`, the backup side stays enabled while `backup_busy` is high. The edge after `backup_busy` is seen low drops `backup_side_en`, and the following edge raises `main_side_en`.
- R9: `backup_active` is high exactly when the backup side is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_transient | input | 1 | Monitor reports a transient fault (level) |
| flt_permanent | input | 1 | Monitor reports a permanent fault |
| vdd_ok | input | 1 | Main-controller supply is within its window |
| main_recovered | input | 1 | Main controller reports it is healthy again |
| backup_busy | input | 1 | Backup side still has in-progress tasks |
| main_rst | output | 1 | Reset pulse to the main controller |
| warn_req | output | 1 | One-cycle request to send a warning message |
| main_side_en | output | 1 | Enable for main-side controllers and transceivers |
| backup_side_en | output | 1 | Enable for backup-side controllers and transceivers |
| backup_active | output | 1 | Backup side currently owns the buses |

## Verification
The bench builds the block with PERSIST_CYC=8, SAMPLE_CYC=16, RST_WIDTH=3 and RETRY_CYC=10. With these values, the persistence boundary (8 edges against 9), several reset retries and the full range of supply-sample latency each fit in a few dozen cycles. The short window also lets one run cover the whole path: hand-over, draining, hand-back and the one-cycle gaps between enables, all at exact cycle positions.

// File: rtl/fs_pkg.sv
package fs_pkg;

  typedef enum logic [2:0] {
    SV_NORMAL,
    SV_TRANSIENT,
    SV_TR_RESET,
    SV_WARN,
    SV_FAULTED,
    SV_DRAIN,
    SV_RETURN
  } sup_state_t;

  // True on the final count of a modulo-limit counter.
  function automatic logic last_tick(input logic [31:0] count, input logic [31:0] limit);
    return count == (limit - 32'd1);
  endfunction

endpackage

// File: rtl/fs_vdd_sampler.sv
module fs_vdd_sampler #(
  parameter int unsigned SAMPLE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vdd_ok,
  output logic vdd_bad
);
  import fs_pkg::*;

  localparam int unsigned CW = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;

  logic [CW-1:0] cnt;
  logic          sample_tick;

  assign sample_tick = last_tick(32'(cnt), 32'(SAMPLE_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      vdd_bad <= 1'b0;
    end else begin
      vdd_bad <= sample_tick & ~vdd_ok;
      cnt     <= sample_tick ? '0 : cnt + CW'(1);
    end
  end

  generate
    if (SAMPLE_CYC > 1) begin : g_spacing
      AST_VDD_SAMPLE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_bad |=> !vdd_bad); // R7
    end
  endgenerate

endmodule

// File: rtl/fs_reset_pulser.sv
module fs_reset_pulser #(
  parameter int unsigned RST_WIDTH = 16,
  parameter int unsigned RETRY_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  output logic pulse_o
);
  import fs_pkg::*;

  localparam int unsigned PW = $clog2(RETRY_CYC + 1);
  localparam int unsigned WW = $clog2(RST_WIDTH + 1);

  logic [PW-1:0] per_cnt;
  logic [WW-1:0] wid_cnt;
  logic          fire;

  assign fire = active & (restart | (per_cnt == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_cnt <= '0;
    end else if (!active) begin
      per_cnt <= '0;
    end else if (fire) begin
      per_cnt <= PW'(1);
    end else if (last_tick(32'(per_cnt), 32'(RETRY_CYC))) begin
      per_cnt <= '0;
    end else begin
      per_cnt <= per_cnt + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_o <= 1'b0;
      wid_cnt <= '0;
    end else if (fire) begin
      pulse_o <= 1'b1;
      wid_cnt <= '0;
    end else if (pulse_o) begin
      if (last_tick(32'(wid_cnt), 32'(RST_WIDTH))) pulse_o <= 1'b0;
      else                                         wid_cnt <= wid_cnt + WW'(1);
    end
  end

  AST_PULSE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(active)); // R4

endmodule

// File: rtl/fs_handover.sv
module fs_handover (
  input  logic clk,
  input  logic rst_n,
  input  logic want_backup,
  output logic main_en,
  output logic backup_en
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_en   <= 1'b1;
      backup_en <= 1'b0;
    end else if (want_backup) begin
      if (main_en) main_en   <= 1'b0;
      else         backup_en <= 1'b1;
    end else begin
      if (backup_en) backup_en <= 1'b0;
      else           main_en   <= 1'b1;
    end
  end

  AST_NEVER_BOTH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_en && backup_en)); // R6
  AST_BACKUP_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(backup_en) |-> !$past(main_en)); // R6
  AST_MAIN_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_en) |-> !$past(backup_en)); // R6

endmodule

// File: rtl/fs_supervisor.sv
module fs_supervisor #(
  parameter int unsigned PERSIST_CYC = 500000,
  parameter int unsigned SAMPLE_CYC  = 1000,
  parameter int unsigned RST_WIDTH   = 16,
  parameter int unsigned RETRY_CYC   = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flt_transient,
  input  logic flt_permanent,
  input  logic vdd_ok,
  input  logic main_recovered,
  input  logic backup_busy,
  output logic main_rst,
  output logic warn_req,
  output logic main_side_en,
  output logic backup_side_en,
  output logic backup_active
);
  import fs_pkg::*;

  localparam int unsigned TW = $clog2(PERSIST_CYC + 1);

  sup_state_t    state, state_nx;
  logic [TW-1:0] pcnt;
  logic          vdd_bad;
  logic          perm_evt;
  logic          persist_over;
  logic          pulse_active;
  logic          pulse_restart;
  logic          want_backup;

  assign perm_evt      = flt_permanent | vdd_bad;
  assign persist_over  = last_tick(32'(pcnt), 32'(PERSIST_CYC));
  assign pulse_active  = (state == SV_TR_RESET) || (state == SV_WARN) || (state == SV_FAULTED);
  assign pulse_restart = (state == SV_WARN);
  assign want_backup   = (state == SV_FAULTED) || (state == SV_DRAIN);
  assign warn_req      = (state == SV_WARN);
  assign backup_active = backup_side_en;

  fs_vdd_sampler #(.SAMPLE_CYC(SAMPLE_CYC)) i_vdd (
    .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .vdd_bad(vdd_bad)
  );

  fs_reset_pulser #(.RST_WIDTH(RST_WIDTH), .RETRY_CYC(RETRY_CYC)) i_pulser (
    .clk(clk), .rst_n(rst_n), .active(pulse_active), .restart(pulse_restart), .pulse_o(main_rst)
  );

  fs_handover i_handover (
    .clk(clk), .rst_n(rst_n), .want_backup(want_backup),
    .main_en(main_side_en), .backup_en(backup_side_en)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      SV_NORMAL: begin
        if (perm_evt)           state_nx = SV_WARN;
        else if (flt_transient) state_nx = SV_TRANSIENT;
      end
      SV_TRANSIENT: begin
        if (perm_evt)           state_nx = SV_WARN;
        else if (!flt_transient) state_nx = SV_NORMAL;
        else if (persist_over)  state_nx = SV_TR_RESET;
      end
      SV_TR_RESET: begin
        if (perm_evt)           state_nx = SV_WARN;
        else if (!flt_transient) state_nx = SV_NORMAL;
      end
      SV_WARN:    state_nx = SV_FAULTED;
      SV_FAULTED: if (main_recovered) state_nx = SV_DRAIN;
      SV_DRAIN:   if (!backup_busy && backup_side_en) state_nx = SV_RETURN;
      SV_RETURN:  if (main_side_en) state_nx = SV_NORMAL;
      default:    state_nx = SV_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SV_NORMAL;
      pcnt  <= '0;
    end else begin
      state <= state_nx;
      if (state != SV_TRANSIENT) pcnt <= '0;
      else                       pcnt <= pcnt + TW'(1);
    end
  end

  AST_WARN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    warn_req |=> !warn_req); // R5
  AST_WARN_THEN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    warn_req |=> main_rst); // R5
  AST_NORMAL_BACKUP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SV_NORMAL) |-> !backup_side_en); // R6
  AST_TRANSIENT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SV_TRANSIENT) |-> (32'(pcnt) < 32'(PERSIST_CYC))); // R2
  AST_DRAIN_HOLDS_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SV_DRAIN && backup_busy && backup_side_en) |=> backup_side_en); // R8

endmodule

// File: tb/test_fs_supervisor.sv
module test_fs_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int P_PERSIST  = 8;
  localparam int P_SAMPLE   = 16;
  localparam int P_RSTW     = 3;
  localparam int P_RETRY    = 10;
  localparam int WD_LIMIT   = 20000;

  localparam int K_WARN_R = 0;
  localparam int K_WARN_F = 1;
  localparam int K_RST_R  = 2;
  localparam int K_RST_F  = 3;
  localparam int K_MAIN_F = 4;
  localparam int K_MAIN_R = 5;
  localparam int K_BK_R   = 6;
  localparam int K_BK_F   = 7;

  typedef struct {
    int    kind;
    int    cyc;
    string req;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flt_transient = 1'b0;
  logic flt_permanent = 1'b0;
  logic vdd_ok = 1'b1;
  logic main_recovered = 1'b0;
  logic backup_busy = 1'b0;
  logic main_rst, warn_req, main_side_en, backup_side_en, backup_active;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int gap_viol = 0;
  ev_t exp_q[$];
  ev_t got_q[$];
  logic p_warn, p_rst, p_main, p_bk;

  fs_supervisor #(
    .PERSIST_CYC(P_PERSIST), .SAMPLE_CYC(P_SAMPLE),
    .RST_WIDTH(P_RSTW), .RETRY_CYC(P_RETRY)
  ) i_fs_supervisor (
    .clk(clk), .rst_n(rst_n), .flt_transient(flt_transient), .flt_permanent(flt_permanent),
    .vdd_ok(vdd_ok), .main_recovered(main_recovered), .backup_busy(backup_busy),
    .main_rst(main_rst), .warn_req(warn_req), .main_side_en(main_side_en),
    .backup_side_en(backup_side_en), .backup_active(backup_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic log_ev(input int kind);
    ev_t e;
    e.kind = kind; e.cyc = cyc; e.req = "";
    got_q.push_back(e);
  endtask

  // Monitor: samples away from the active edge and logs output transitions.
  always @(negedge clk) begin
    if (!rst_n) begin
      p_warn = 1'b0; p_rst = 1'b0; p_main = 1'b1; p_bk = 1'b0;
    end else begin
      if (main_side_en && backup_side_en) gap_viol++;
      if (backup_side_en && !p_bk && p_main) gap_viol++;
      if (main_side_en && !p_main && p_bk) gap_viol++;
      if (warn_req && !p_warn) log_ev(K_WARN_R);
      if (!warn_req && p_warn) log_ev(K_WARN_F);
      if (main_rst && !p_rst)  log_ev(K_RST_R);
      if (!main_rst && p_rst)  log_ev(K_RST_F);
      if (!main_side_en && p_main) log_ev(K_MAIN_F);
      if (main_side_en && !p_main) log_ev(K_MAIN_R);
      if (backup_side_en && !p_bk) log_ev(K_BK_R);
      if (!backup_side_en && p_bk) log_ev(K_BK_F);
      p_warn = warn_req; p_rst = main_rst; p_main = main_side_en; p_bk = backup_side_en;
    end
  end

  task automatic expect_ev(input int kind, input int at, input string req);
    ev_t e;
    e.kind = kind; e.cyc = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic score(input string extra_req);
    ev_t e, g;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_chk++;
      if (got_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s event kind %0d: actual none expected cycle %0d", e.req, e.kind, e.cyc);
      end else begin
        g = got_q.pop_front();
        if (g.kind != e.kind || g.cyc != e.cyc) begin
          n_bad++;
          $display("FAIL %s event: actual kind %0d at %0d expected kind %0d at %0d",
                   e.req, g.kind, g.cyc, e.kind, e.cyc);
        end
      end
    end
    n_chk++;
    if (got_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s extra events: actual %0d expected 0 (first kind %0d at %0d)",
               extra_req, got_q.size(), got_q[0].kind, got_q[0].cyc);
    end
    got_q.delete();
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc == WD_LIMIT) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual cycle %0d expected below %0d", cyc, WD_LIMIT);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_eq("R1", "main_side_en", main_side_en, 1);
    check_eq("R1", "backup_side_en", backup_side_en, 0);
    check_eq("R1", "backup_active", backup_active, 0);
    check_eq("R1", "main_rst", main_rst, 0);
    check_eq("R1", "warn_req", warn_req, 0);

    // R2: transient on exactly PERSIST edges is ignored
    c = cyc;
    flt_transient = 1'b1;
    wait_to(c + P_PERSIST);
    flt_transient = 1'b0;
    wait_to(c + 40);
    check_eq("R2", "main_side_en after short transient", main_side_en, 1);
    score("R2");

    // R3/R4: transient on PERSIST+1 edges and beyond
    c = cyc;
    flt_transient = 1'b1;
    expect_ev(K_RST_R, c + 10, "R3");
    expect_ev(K_RST_F, c + 13, "R3");
    expect_ev(K_RST_R, c + 20, "R4");
    expect_ev(K_RST_F, c + 23, "R4");
    wait_to(c + 25);
    flt_transient = 1'b0;
    wait_to(c + 60);
    score("R4");

    // R5/R4/R8/R9: permanent fault, hand-over, retries, drain, hand-back
    c = cyc;
    flt_permanent = 1'b1;
    backup_busy = 1'b1;
    expect_ev(K_WARN_R, c + 1, "R5");
    expect_ev(K_WARN_F, c + 2, "R5");
    expect_ev(K_RST_R,  c + 2, "R5");
    expect_ev(K_MAIN_F, c + 3, "R5");
    expect_ev(K_BK_R,   c + 4, "R5");
    expect_ev(K_RST_F,  c + 5, "R3");
    expect_ev(K_RST_R,  c + 12, "R4");
    expect_ev(K_RST_F,  c + 15, "R4");
    expect_ev(K_BK_F,   c + 32, "R8");
    expect_ev(K_MAIN_R, c + 33, "R8");
    wait_to(c + 1);
    flt_permanent = 1'b0;
    wait_to(c + 10);
    check_eq("R9", "backup_active while backup owns", backup_active, 1);
    wait_to(c + 16);
    main_recovered = 1'b1;
    wait_to(c + 17);
    main_recovered = 1'b0;
    wait_to(c + 28);
    check_eq("R8", "backup_side_en while busy", backup_side_en, 1);
    wait_to(c + 30);
    backup_busy = 1'b0;
    wait_to(c + 50);
    check_eq("R9", "backup_active after hand-back", backup_active, 0);
    score("R4");

    // R7: supply sample out of window
    c = cyc;
    vdd_ok = 1'b0;
    w = -1;
    for (int k = 0; k < P_SAMPLE + 6; k++) begin
      @(negedge clk);
      if (warn_req && w < 0) w = cyc;
    end
    n_chk++;
    if (w < 0 || (w - c) < 2 || (w - c) > P_SAMPLE + 1) begin
      n_bad++;
      $display("FAIL R7 warn latency: actual %0d expected 2..%0d", (w < 0) ? -1 : (w - c), P_SAMPLE + 1);
    end
    check_eq("R7", "backup_side_en after supply fault", backup_side_en, 1);
    check_eq("R7", "main_side_en after supply fault", main_side_en, 0);
    vdd_ok = 1'b1;
    @(negedge clk);
    main_recovered = 1'b1;
    @(negedge clk);
    main_recovered = 1'b0;
    repeat (8) @(negedge clk);
    check_eq("R8", "main_side_en after recovery", main_side_en, 1);
    check_eq("R8", "backup_side_en after recovery", backup_side_en, 0);
    got_q.delete();

    // R6: no overlap and a gap on every change of ownership
    check_eq("R6", "overlap or missing gap count", gap_viol, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule